// File: doc/BRIEF.md
# Byte-per-pin GPIO interrupt controller

A general-purpose I/O controller in which every pin owns one byte in each of nine register banks: direction, output value, input value, interrupt enable, polarity, edge select, acknowledge, status and dual-edge. Only bit 0 of a byte carries state. Software reaches pin n of a bank at the bank's base address plus n. Reads and writes go over a small single-cycle register bus.

Each pin input passes through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one clock earlier. The edge, dual-edge and polarity bytes choose the pin's trigger: active-high level, active-low level, rising edge, falling edge, or both edges. In level mode the pin's status bit tracks the qualified level. In edge mode the status bit is sticky until software writes the pin's acknowledge byte.

Seven parent interrupt lines leave the block. Line k is the OR of (status AND enable) over every pin whose index modulo 7 equals k. The block has its own active-low reset.

Top module: `pin_event_gpio`

## Requirements
- R1: After `rstN` is low, every direction, output, enable, polarity, edge and dual-edge byte reads 0, `pinOe` and `pinOut` are all 0, and `parentIrq` is 0.
- R2: Bank bases are 0x800 direction, 0x900 output, 0xA00 input, 0xB00 enable, 0xC00 polarity, 0xD00 edge select, 0xE00 acknowledge, 0xF00 status and 0xF80 dual-edge. Pin n sits at base + n, and only bit 0 of written data is stored. A read returns the bit in bit 0 with bits 7:1 zero, on `busRdata` in the cycle after the read request. A pin index at or above the pin count, or an unmapped address, reads 0 and a write there changes nothing.
- R3: `pinOe[n]` equals direction bit n (1 = output) and `pinOut[n]` equals output bit n.
- R4: A read of the input bank returns the pin level after the two-flop synchroniser.
- R5: With edge byte 0 (level mode), status follows the pin each cycle: it equals the pin level when polarity is 1 and the inverted level when polarity is 0. A write to the acknowledge byte has no lasting effect.
- R6: With edge byte 1 and dual byte 0, status sets on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge does not set it, and once set it stays set.
- R7: With edge byte 1 and dual byte 1, both edges set status whatever the polarity byte holds.
- R8: In edge mode, writing a byte with bit 0 set to a pin's acknowledge address clears that pin's status. Writing bit 0 clear does nothing. The acknowledge bank always reads 0, and writes to the status bank are ignored.
- R9: If an edge and an acknowledge for the same pin happen in the same cycle, status is left set.
- R10: `parentIrq[k]` is the OR of (status AND enable) over pins p with p mod 7 == k. A pin whose enable byte is 0 never drives its parent line, though its status stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset for the whole controller |
| busSel | input | 1 | Register access request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid the cycle after a read |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Output values |
| pinOe | output | 32 | Output enables |
| parentIrq | output | 7 | Parent interrupt lines |

## Verification
The hardest case to reach is R9: an acknowledge write that lands in exactly the cycle in which the synchronised edge is seen. Because of the synchroniser, that cycle is three clocks after the pin moves. The bench changes the pin on a falling clock edge, waits two rising edges, and then issues the acknowledge write so that it is sampled on the third. Everything else comes from a sweep over all 32 pins and all five trigger modes. In that sweep the bench predicts the status value and the parent line index (p mod 7) arithmetically. It also exercises the opposite edge, masking and acknowledge for every pin.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  localparam int BUS_AW = 12;
  localparam int IDX_W  = 8;

  typedef enum logic [3:0] {
    BK_NONE,
    BK_DIR,
    BK_OUT,
    BK_IN,
    BK_EN,
    BK_POL,
    BK_EDGE,
    BK_CLR,
    BK_STS,
    BK_DUAL
  } bank_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic             wr;
    logic             rd;
    bank_e            bank;
    logic [IDX_W-1:0] idx;
    logic             bitVal;
  } strobe_t;

endpackage

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output strobe_t           stb
);

  localparam logic [IDX_W:0] PIN_LIMIT = (IDX_W+1)'(NUM_PINS);

  bank_e            rawBank;
  logic [IDX_W-1:0] rawIdx;
  logic             inRange;

  always_comb begin
    rawIdx  = busAddr[IDX_W-1:0];
    rawBank = BK_NONE;
    case (busAddr[11:8])
      4'h8:    rawBank = BK_DIR;
      4'h9:    rawBank = BK_OUT;
      4'hA:    rawBank = BK_IN;
      4'hB:    rawBank = BK_EN;
      4'hC:    rawBank = BK_POL;
      4'hD:    rawBank = BK_EDGE;
      4'hE:    rawBank = BK_CLR;
      4'hF: begin
        rawIdx  = {1'b0, busAddr[6:0]};
        rawBank = busAddr[7] ? BK_DUAL : BK_STS;
      end
      default: rawBank = BK_NONE;
    endcase
  end

  assign inRange = ({1'b0, rawIdx} < PIN_LIMIT);

  always_comb begin
    stb.wr     = busSel & busWe;
    stb.rd     = busSel & ~busWe;
    stb.bank   = inRange ? rawBank : BK_NONE;
    stb.idx    = rawIdx;
    stb.bitVal = busWdata[0];
  end

endmodule

// File: rtl/pin_event_dp.sv
module pin_event_dp
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int NUM_PARENTS = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [NUM_PINS-1:0]    pinIn,
  output logic [NUM_PINS-1:0]    pinOut,
  output logic [NUM_PINS-1:0]    pinOe,
  output logic [NUM_PARENTS-1:0] parentIrq,
  output logic [7:0]             busRdata
);

  logic [NUM_PINS-1:0] syncA, syncB, prevB;
  logic [NUM_PINS-1:0] dirQ, outQ, enQ, polQ, edgeQ, dualQ, stsQ;
  logic [NUM_PINS-1:0] dirD, outD, enD, polD, edgeD, dualD, stsD;
  logic [NUM_PINS-1:0] irqPin;
  logic [NUM_PINS-1:0] bankVec;
  logic                selBit;
  logic [7:0]          rdQ;

  function automatic logic cfgNext(strobe_t s, bank_e b, logic sel, logic cur);
    return (s.wr && sel && (s.bank == b)) ? s.bitVal : cur;
  endfunction

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic selHere, clrHere, riseSeen, fallSeen, edgeHit, lvlActive;

    assign selHere   = (stb.idx == 8'(p));
    assign clrHere   = stb.wr && selHere && (stb.bank == BK_CLR) && stb.bitVal;
    assign riseSeen  = syncB[p] & ~prevB[p];
    assign fallSeen  = ~syncB[p] & prevB[p];
    assign edgeHit   = dualQ[p] ? (riseSeen | fallSeen)
                                : (polQ[p] ? riseSeen : fallSeen);
    assign lvlActive = polQ[p] ? syncB[p] : ~syncB[p];

    assign dirD[p]  = cfgNext(stb, BK_DIR,  selHere, dirQ[p]);
    assign outD[p]  = cfgNext(stb, BK_OUT,  selHere, outQ[p]);
    assign enD[p]   = cfgNext(stb, BK_EN,   selHere, enQ[p]);
    assign polD[p]  = cfgNext(stb, BK_POL,  selHere, polQ[p]);
    assign edgeD[p] = cfgNext(stb, BK_EDGE, selHere, edgeQ[p]);
    assign dualD[p] = cfgNext(stb, BK_DUAL, selHere, dualQ[p]);
    // edge mode: a detected edge overrides an acknowledge in the same cycle
    assign stsD[p]  = edgeQ[p] ? (edgeHit | (stsQ[p] & ~clrHere)) : lvlActive;

    // R6: latched edge status persists while nothing is written
    p_edge_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      (edgeQ[p] && stsQ[p] && !stb.wr) |=> stsQ[p])
      else $error("edge status dropped without acknowledge");

    // R9: an edge always leaves status set, acknowledge or not
    p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
      (edgeQ[p] && edgeHit) |=> stsQ[p])
      else $error("edge lost against acknowledge");

    // R8: acknowledge without a coincident edge clears status
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
      (edgeQ[p] && clrHere && !edgeHit) |=> !stsQ[p])
      else $error("acknowledge did not clear status");

    // R5: active-high level mode with a low pin gives no status
    p_level_low_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!edgeQ[p] && polQ[p] && !syncB[p]) |=> !stsQ[p])
      else $error("level status set with inactive pin");
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
      dirQ  <= '0;
      outQ  <= '0;
      enQ   <= '0;
      polQ  <= '0;
      edgeQ <= '0;
      dualQ <= '0;
      stsQ  <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
      dirQ  <= dirD;
      outQ  <= outD;
      enQ   <= enD;
      polQ  <= polD;
      edgeQ <= edgeD;
      dualQ <= dualD;
      stsQ  <= stsD;
    end
  end

  assign irqPin = stsQ & enQ;
  assign pinOut = outQ;
  assign pinOe  = dirQ;

  for (genvar k = 0; k < NUM_PARENTS; k++) begin : g_parent
    logic orK;
    always_comb begin
      orK = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
        if ((p % NUM_PARENTS) == k) orK = orK | irqPin[p];
      end
    end
    assign parentIrq[k] = orK;
  end

  // R10: with every pin masked no parent line may be high
  p_mask_blocks_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    (enQ == '0) |-> (parentIrq == '0))
    else $error("parent interrupt with all pins masked");

  always_comb begin
    case (stb.bank)
      BK_DIR:  bankVec = dirQ;
      BK_OUT:  bankVec = outQ;
      BK_IN:   bankVec = syncB;
      BK_EN:   bankVec = enQ;
      BK_POL:  bankVec = polQ;
      BK_EDGE: bankVec = edgeQ;
      BK_STS:  bankVec = stsQ;
      BK_DUAL: bankVec = dualQ;
      default: bankVec = '0;
    endcase
    selBit = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (stb.idx == 8'(p)) selBit = bankVec[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rdQ <= '0;
    else if (stb.rd) rdQ <= {7'b0, selBit};
  end

  assign busRdata = rdQ;

  // R8: the acknowledge bank reads back as zero
  p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && stb.bank == BK_CLR) |=> (busRdata == 8'h00))
    else $error("acknowledge bank returned nonzero");

endmodule

// File: rtl/pin_event_gpio.sv
module pin_event_gpio
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int NUM_PARENTS = 7
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWe,
  input  logic [11:0]            busAddr,
  input  logic [7:0]             busWdata,
  output logic [7:0]             busRdata,
  input  logic [NUM_PINS-1:0]    pinIn,
  output logic [NUM_PINS-1:0]    pinOut,
  output logic [NUM_PINS-1:0]    pinOe,
  output logic [NUM_PARENTS-1:0] parentIrq
);

  strobe_t stb;

  pin_event_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .busSel   (busSel),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  pin_event_dp #(.NUM_PINS(NUM_PINS), .NUM_PARENTS(NUM_PARENTS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .parentIrq (parentIrq),
    .busRdata  (busRdata)
  );

endmodule

// File: tb/pin_event_gpio_tb.sv
module pin_event_gpio_tb;

  localparam logic [11:0] A_DIR  = 12'h800;
  localparam logic [11:0] A_OUT  = 12'h900;
  localparam logic [11:0] A_IN   = 12'hA00;
  localparam logic [11:0] A_EN   = 12'hB00;
  localparam logic [11:0] A_POL  = 12'hC00;
  localparam logic [11:0] A_EDGE = 12'hD00;
  localparam logic [11:0] A_CLR  = 12'hE00;
  localparam logic [11:0] A_STS  = 12'hF00;
  localparam logic [11:0] A_DUAL = 12'hF80;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWe;
  logic [11:0] busAddr;
  logic [7:0]  busWdata, busRdata;
  logic [31:0] pinIn, pinOut, pinOe;
  logic [6:0]  parentIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_event_gpio u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .parentIrq(parentIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] d);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [31:0] expOe, expOut, pat;
    logic [6:0]  hit;
    logic        polV, edgeV, dualV, startV;

    rstN = 1'b0; busSel = 1'b0; busWe = 1'b0; busAddr = '0; busWdata = '0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pinOe", pinOe, 32'h0);
    chk("R1 pinOut", pinOut, 32'h0);
    chk("R1 parentIrq", parentIrq, 7'h0);
    for (int p = 0; p < 32; p += 31) begin
      busRead(A_DIR + 12'(p), rd);  chk("R1 dir", rd, 0);
      busRead(A_OUT + 12'(p), rd);  chk("R1 out", rd, 0);
      busRead(A_EN + 12'(p), rd);   chk("R1 en", rd, 0);
      busRead(A_POL + 12'(p), rd);  chk("R1 pol", rd, 0);
      busRead(A_EDGE + 12'(p), rd); chk("R1 edge", rd, 0);
      busRead(A_DUAL + 12'(p), rd); chk("R1 dual", rd, 0);
    end

    // R3 and R2: direction/output with junk in upper data bits
    expOe = '0; expOut = '0;
    for (int p = 0; p < 32; p++) begin
      expOe[p]  = (p % 3 == 0);
      expOut[p] = (p % 2 == 1);
      busWrite(A_DIR + 12'(p), {7'h7F, expOe[p]});
      busWrite(A_OUT + 12'(p), {7'h55, expOut[p]});
    end
    chk("R3 pinOe", pinOe, expOe);
    chk("R3 pinOut", pinOut, expOut);
    for (int p = 0; p < 32; p++) begin
      busRead(A_DIR + 12'(p), rd);
      chk("R2 dir readback", rd, {7'b0, expOe[p]});
    end

    // R2: out-of-range index and unmapped bank
    busWrite(A_DIR + 12'd40, 8'h01);
    chk("R2 out-of-range write", pinOe, expOe);
    busRead(A_DIR + 12'd40, rd);  chk("R2 out-of-range read", rd, 0);
    busWrite(12'h100, 8'h01);
    busRead(12'h100, rd);         chk("R2 unmapped read", rd, 0);
    busWrite(A_DUAL + 12'd7, 8'h01);
    busRead(A_DUAL + 12'd7, rd);  chk("R2 dual bank at 0xF80", rd, 1);
    busWrite(A_DUAL + 12'd7, 8'h00);

    // R4: synchronised input readback
    pat = 32'hA5C3_1E69;
    pinIn = pat;
    settle();
    for (int p = 0; p < 32; p++) begin
      busRead(A_IN + 12'(p), rd);
      chk("R4 input bank", rd, {7'b0, pat[p]});
    end
    pinIn = '0;
    settle();

    // R8: acknowledge bank reads zero
    busWrite(A_CLR + 12'd2, 8'h01);
    busRead(A_CLR + 12'd2, rd);  chk("R8 ack reads zero", rd, 0);

    // sweep every pin through all five trigger modes
    for (int p = 0; p < 32; p++) begin
      hit = 7'(1 << (p % 7));
      for (int m = 0; m < 5; m++) begin
        polV  = (m == 0 || m == 2) ? 1'b1 : (m == 4 ? 1'(p % 2) : 1'b0);
        edgeV = (m >= 2);
        dualV = (m == 4);
        startV = (m == 1 || m == 3);
        pinIn[p] = startV;
        settle();
        busWrite(A_POL + 12'(p), {7'b0, polV});
        busWrite(A_EDGE + 12'(p), {7'b0, edgeV});
        busWrite(A_DUAL + 12'(p), {7'b0, dualV});
        busWrite(A_CLR + 12'(p), 8'h01);
        busWrite(A_EN + 12'(p), 8'h01);
        busRead(A_STS + 12'(p), rd);
        chk(m < 2 ? "R5 idle status" : "R6 idle status", rd, 0);
        chk("R10 idle parent", parentIrq, 7'h0);

        pinIn[p] = ~startV;
        settle();
        busRead(A_STS + 12'(p), rd);
        chk(m < 2 ? "R5 active status" : (m == 4 ? "R7 first edge" : "R6 trigger edge"), rd, 1);
        chk("R10 parent index p mod 7", parentIrq, hit);

        busWrite(A_EN + 12'(p), 8'h00);
        chk("R10 masked parent", parentIrq, 7'h0);
        busRead(A_STS + 12'(p), rd);
        chk("R10 masked status readable", rd, 1);
        busWrite(A_EN + 12'(p), 8'h01);

        if (m < 2) begin
          busWrite(A_CLR + 12'(p), 8'h01);
          busRead(A_STS + 12'(p), rd);
          chk("R5 ack ignored in level", rd, 1);
          pinIn[p] = startV;
          settle();
          busRead(A_STS + 12'(p), rd);
          chk("R5 level released", rd, 0);
          chk("R5 parent released", parentIrq, 7'h0);
        end else begin
          busRead(A_STS + 12'(p), rd);
          chk("R6 sticky", rd, 1);
          busWrite(A_CLR + 12'(p), 8'h01);
          busRead(A_STS + 12'(p), rd);
          chk("R8 ack clears", rd, 0);
          pinIn[p] = startV;
          settle();
          busRead(A_STS + 12'(p), rd);
          chk(m == 4 ? "R7 second edge" : "R6 opposite edge ignored", rd, {7'b0, (m == 4)});
          chk(m == 4 ? "R7 parent" : "R6 parent", parentIrq, (m == 4) ? hit : 7'h0);
          busWrite(A_CLR + 12'(p), 8'h01);
        end
        busWrite(A_EN + 12'(p), 8'h00);
      end
      pinIn[p] = 1'b0;
      busWrite(A_EDGE + 12'(p), 8'h00);
      busWrite(A_DUAL + 12'(p), 8'h00);
      busWrite(A_POL + 12'(p), 8'h00);
    end
    settle();

    // R10: two pins sharing parent line 3
    busWrite(A_EDGE + 12'd3, 8'h01);  busWrite(A_POL + 12'd3, 8'h01);
    busWrite(A_EDGE + 12'd10, 8'h01); busWrite(A_POL + 12'd10, 8'h01);
    busWrite(A_CLR + 12'd3, 8'h01);   busWrite(A_CLR + 12'd10, 8'h01);
    busWrite(A_EN + 12'd3, 8'h01);    busWrite(A_EN + 12'd10, 8'h01);
    pinIn[3] = 1'b1; pinIn[10] = 1'b1;
    settle();
    chk("R10 shared line both", parentIrq, 7'h08);
    busWrite(A_CLR + 12'd3, 8'h01);
    chk("R10 shared line one left", parentIrq, 7'h08);
    busWrite(A_CLR + 12'd10, 8'h01);
    chk("R10 shared line cleared", parentIrq, 7'h00);

    // R8: status bank write ignored, ack with bit0=0 ignored
    busWrite(A_STS + 12'd3, 8'h01);
    busRead(A_STS + 12'd3, rd);  chk("R8 status write ignored", rd, 0);
    pinIn[3] = 1'b0; settle();
    pinIn[3] = 1'b1; settle();
    busWrite(A_CLR + 12'd3, 8'hFE);
    busRead(A_STS + 12'd3, rd);  chk("R8 ack bit0 clear ignored", rd, 1);
    busWrite(A_CLR + 12'd3, 8'h01);

    // R9: edge and acknowledge in the same cycle
    busWrite(A_EDGE + 12'd5, 8'h01); busWrite(A_POL + 12'd5, 8'h01);
    busWrite(A_EN + 12'd5, 8'h01);
    busWrite(A_CLR + 12'd5, 8'h01);
    busRead(A_STS + 12'd5, rd);  chk("R9 precondition", rd, 0);
    pinIn[5] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    busWrite(A_CLR + 12'd5, 8'h01);
    busRead(A_STS + 12'd5, rd);  chk("R9 set wins over ack", rd, 1);
    chk("R9 parent", parentIrq, 7'h20);
    busWrite(A_CLR + 12'd5, 8'h01);
    busRead(A_STS + 12'd5, rd);  chk("R9 later ack clears", rd, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule